// File: doc/BRIEF.md
# CPU and Video Shared-RAM Phase Sequencer

This block lets an 8-bit CPU and a display scanout engine use one single-port RAM without a full arbiter. A two-bit phase counter runs freely on the system clock. Its four steps form one CPU clock period. The first half of the period belongs to the CPU and the second half belongs to the video fetch. The counter's high bit is the CPU clock, its inverse clocks the video-side logic, and a one-cycle enable marks each CPU clock edge.

The block also shapes CPU timing. It keeps a modulo-4 count of CPU clocks (T-states). When an opcode fetch (M1) begins off a four-clock boundary, the active-low wait line is held low until the count wraps, so every instruction fills a whole number of four-clock groups. Each memory write receives one extra wait state before the RAM write strobe is issued. An I/O read always returns zero. Video fetches go to a 16 KiB window at the top of the address space.

Top module: `mem_phase_arbiter`

## Requirements
- R1: The phase counter steps 0,1,2,3 and repeats, one step per `clk`. `cpu_clk` is high in phases 2 and 3. `vid_clk` is its inverse. `cpu_ce` is high in phase 3 only. A "tick" is the `clk` edge that ends phase 3.
- R2: In phases 0 and 1, `ram_addr` equals `cpu_addr`. In phases 2 and 3, it equals `VID_BASE` (0xC000) OR'ed with the 14-bit `vid_addr`.
- R3: `vid_data` takes `ram_rdata` at the edge that ends phase 3. `vid_valid` is high for the following phase 0 only.
- R4: A memory read (`cpu_mreq_n`=0, `cpu_rd_n`=0) loads `ram_rdata` into `cpu_din` at the edge that ends phase 1.
- R5: An I/O read (`cpu_iorq_n`=0, `cpu_rd_n`=0, `cpu_m1_n`=1, `cpu_mreq_n`=1) loads 0x00 into `cpu_din` at the edge that ends phase 1.
- R6: At the first tick that sees a memory write (`cpu_mreq_n`=0, `cpu_wr_n`=0), `cpu_wait_n` goes low for exactly one CPU clock. `ram_we` is asserted only in phase 0, only after that wait has ended, and only while the write is still held. It then carries `cpu_addr` and `cpu_dout`. A memory read adds no wait.
- R7: A T-state count starts at 0 and advances by one, modulo 4, at every tick. Suppose a tick sees `cpu_m1_n` low after it was high at the previous tick, and the count at that tick is k. Then `cpu_wait_n` is low for 3−k CPU clocks when k is 1 or 2, and it rises at the tick where the count steps from 3 to 0. With k = 0 or 3 no wait is inserted. The wait line changes only at ticks.
- R8: While `rst_n` is low, the phase and T-state counts are zero: `cpu_clk`=0, `vid_clk`=1, `cpu_ce`=0, `cpu_wait_n`=1, `ram_we`=0, `vid_valid`=0 and `cpu_din`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four per CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk | output | 1 | CPU clock (phase MSB) |
| vid_clk | output | 1 | Inverted CPU clock for video-side logic |
| cpu_ce | output | 1 | High in the cycle before each CPU clock edge |
| cpu_addr | input | 16 | CPU address bus |
| cpu_dout | input | 8 | CPU write data |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_iorq_n | input | 1 | I/O request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_m1_n | input | 1 | Opcode fetch cycle, active low |
| cpu_din | output | 8 | Read data to the CPU |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |
| vid_addr | input | 14 | Byte offset within the video window |
| vid_data | output | 8 | Last fetched video byte |
| vid_valid | output | 1 | Pulse when `vid_data` is fresh |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data (asynchronous read) |

## Verification
If the phase count is wrong, the slots slide against each other. `ram_addr` then shows the wrong source within one system clock, and read data is captured from the wrong owner. If the T-state count or the M1 edge memory is wrong, the number of wait clocks after an opcode fetch changes. That shows on `cpu_wait_n` at the next tick and is measured for every starting count from 0 to 3. A stuck write-done flag shows up either as a missing wait or as a `ram_we` pulse in the cycle right after the write starts.

// File: rtl/mem_phase_arbiter.sv
`timescale 1ns/1ps
module mem_phase_arbiter #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int VAW = 14,
  parameter logic [AW-1:0] VID_BASE = 'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          cpu_clk,
  output logic          vid_clk,
  output logic          cpu_ce,
  input  logic [15:0]   cpu_addr,
  input  logic [DW-1:0] cpu_dout,
  input  logic          cpu_mreq_n,
  input  logic          cpu_iorq_n,
  input  logic          cpu_rd_n,
  input  logic          cpu_wr_n,
  input  logic          cpu_m1_n,
  output logic [DW-1:0] cpu_din,
  output logic          cpu_wait_n,
  input  logic [VAW-1:0] vid_addr,
  output logic [DW-1:0] vid_data,
  output logic          vid_valid,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  input  logic [DW-1:0] ram_rdata
);
  localparam logic [1:0]    PH_WR    = 2'd0;
  localparam logic [1:0]    PH_CPURD = 2'd1;
  localparam logic [1:0]    PH_LAST  = 2'd3;
  localparam logic [DW-1:0] IO_BYTE  = '0;

  logic [1:0]    ph, tcnt;
  logic          m1_q, wr_done, align, wait_q, vld_q;
  logic [DW-1:0] din_q, vdat_q;

  wire tick      = (ph == PH_LAST);
  wire mem_rd    = !cpu_mreq_n && !cpu_rd_n;
  wire io_rd     = !cpu_iorq_n && !cpu_rd_n && cpu_m1_n;
  wire mem_wr    = !cpu_mreq_n && !cpu_wr_n;
  wire wr_pend   = mem_wr && !wr_done;
  wire new_m1    = !cpu_m1_n && m1_q;
  wire align_set = new_m1 && (tcnt == 2'd1 || tcnt == 2'd2);
  wire align_nx  = align_set || (align && tcnt != 2'd3);

  assign cpu_clk    = ph[1];
  assign vid_clk    = ~ph[1];
  assign cpu_ce     = tick;
  assign cpu_din    = din_q;
  assign cpu_wait_n = wait_q;
  assign vid_data   = vdat_q;
  assign vid_valid  = vld_q;
  assign ram_addr   = ph[1] ? (VID_BASE | AW'(vid_addr)) : AW'(cpu_addr);
  assign ram_wdata  = cpu_dout;
  assign ram_we     = (ph == PH_WR) && mem_wr && wr_done && wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      tcnt    <= '0;
      m1_q    <= 1'b1;
      wr_done <= 1'b0;
      align   <= 1'b0;
      wait_q  <= 1'b1;
      vld_q   <= 1'b0;
      din_q   <= '0;
      vdat_q  <= '0;
    end else begin
      ph    <= ph + 2'd1;
      vld_q <= tick;
      if (tick) vdat_q <= ram_rdata;
      if (ph == PH_CPURD) begin
        if (mem_rd)     din_q <= ram_rdata;
        else if (io_rd) din_q <= IO_BYTE;
      end
      if (tick) begin
        tcnt    <= tcnt + 2'd1;
        m1_q    <= cpu_m1_n;
        wr_done <= mem_wr;
        align   <= align_nx;
        wait_q  <= !(align_nx || wr_pend);
      end
    end
  end
endmodule

// File: rtl/mem_phase_arbiter_chk.sv
`timescale 1ns/1ps
module mem_phase_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ph,
  input logic       cpu_ce,
  input logic       cpu_wait_n,
  input logic       ram_we,
  input logic       cpu_mreq_n,
  input logic       cpu_iorq_n,
  input logic       cpu_rd_n,
  input logic       cpu_wr_n,
  input logic       cpu_m1_n,
  input logic [7:0] cpu_din,
  input logic [7:0] vid_data,
  input logic [7:0] ram_rdata
);
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ph == $past(ph) + 2'd1);

  p_vid_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3) |=> vid_data == $past(ram_rdata));

  p_io_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd1 && !cpu_iorq_n && !cpu_rd_n && cpu_m1_n && cpu_mreq_n) |=> cpu_din == 8'h00);

  p_we_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ph == 2'd0 && !cpu_mreq_n && !cpu_wr_n && cpu_wait_n));

  p_wait_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cpu_ce)) |-> $stable(cpu_wait_n));
endmodule

bind mem_phase_arbiter mem_phase_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .cpu_ce(cpu_ce), .cpu_wait_n(cpu_wait_n),
  .ram_we(ram_we), .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n),
  .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_m1_n(cpu_m1_n),
  .cpu_din(cpu_din), .vid_data(vid_data), .ram_rdata(ram_rdata)
);

// File: tb/tb_mem_phase_arbiter.sv
`timescale 1ns/1ps
module tb_mem_phase_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_clk, vid_clk, cpu_ce, cpu_wait_n, vid_valid, ram_we;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_dout = '0;
  logic        cpu_mreq_n = 1'b1, cpu_iorq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, cpu_m1_n = 1'b1;
  logic [7:0]  cpu_din, vid_data, ram_wdata, ram_rdata;
  logic [13:0] vid_addr = '0;
  logic [15:0] ram_addr;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign ram_rdata = mem_f(ram_addr);

  mem_phase_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .vid_clk(vid_clk), .cpu_ce(cpu_ce),
    .cpu_addr(cpu_addr), .cpu_dout(cpu_dout), .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_m1_n(cpu_m1_n), .cpu_din(cpu_din),
    .cpu_wait_n(cpu_wait_n), .vid_addr(vid_addr), .vid_data(vid_data), .vid_valid(vid_valid),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  int nchk = 0, nfail = 0, nt = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && cpu_ce) nt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic next_tick();
    @(negedge clk);
    while (!cpu_ce) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle_bus();
    cpu_mreq_n = 1; cpu_iorq_n = 1; cpu_rd_n = 1; cpu_wr_n = 1; cpu_m1_n = 1;
  endtask

  // {io, cpu_addr, vid_addr}
  localparam logic [30:0] TBL [6] = '{
    {1'b0, 16'h0000, 14'h0000},
    {1'b0, 16'hC000, 14'h3FFF},
    {1'b1, 16'h00FE, 14'h1234},
    {1'b0, 16'h7A5C, 14'h2001},
    {1'b1, 16'hBC00, 14'h0FF0},
    {1'b0, 16'hFFFF, 14'h00A5}
  };

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(cpu_clk == 0 && vid_clk == 1 && cpu_ce == 0, "R8 clocks in reset", {cpu_clk, vid_clk, cpu_ce}, 3'b010);
    chk(cpu_wait_n == 1 && ram_we == 0 && vid_valid == 0, "R8 strobes in reset", {cpu_wait_n, ram_we, vid_valid}, 3'b100);
    chk(cpu_din == 8'h00, "R8 cpu_din in reset", cpu_din, 0);
    rst_n = 1;

    // R1 phase sequence
    next_tick();
    for (int p = 0; p < 4; p++) begin
      chk(cpu_clk == (p >= 2) && vid_clk == (p < 2) && cpu_ce == (p == 3), "R1 phase outputs",
          {cpu_clk, vid_clk, cpu_ce}, {1'(p >= 2), 1'(p < 2), 1'(p == 3)});
      @(negedge clk);
    end
    next_tick();

    // Table: R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic io;
      logic [15:0] a;
      logic [13:0] v;
      logic [7:0] exp_din;
      logic [15:0] va;
      {io, a, v} = TBL[i];
      va = 16'hC000 | {2'b00, v};
      exp_din = io ? 8'h00 : mem_f(a);
      cpu_addr = a; vid_addr = v; cpu_rd_n = 0;
      if (io) cpu_iorq_n = 0; else cpu_mreq_n = 0;
      @(posedge clk); @(negedge clk);
      chk(ram_addr == a, "R2 cpu slot address", ram_addr, a);
      @(negedge clk);
      chk(ram_addr == va, "R2 video slot address", ram_addr, va);
      next_tick();
      chk(cpu_din == exp_din, io ? "R5 io read data" : "R4 memory read data", cpu_din, exp_din);
      chk(vid_data == mem_f(va), "R3 video byte", vid_data, mem_f(va));
      chk(vid_valid == 1, "R3 vid_valid pulse", vid_valid, 1);
      chk(cpu_wait_n == 1, "R6 no wait on read", cpu_wait_n, 1);
      idle_bus();
      @(negedge clk);
      chk(vid_valid == 0, "R3 vid_valid one cycle", vid_valid, 0);
      next_tick();
    end

    // R6 write wait and strobe
    cpu_addr = 16'h4321; cpu_dout = 8'hA7; cpu_mreq_n = 0; cpu_wr_n = 0;
    chk(ram_we == 0, "R6 no strobe before wait", ram_we, 0);
    next_tick();
    chk(cpu_wait_n == 0, "R6 write wait asserted", cpu_wait_n, 0);
    chk(ram_we == 0, "R6 strobe held during wait", ram_we, 0);
    next_tick();
    chk(cpu_wait_n == 1, "R6 single write wait", cpu_wait_n, 1);
    chk(ram_we == 1 && ram_addr == 16'h4321 && ram_wdata == 8'hA7, "R6 write strobe",
        {ram_we, ram_addr, ram_wdata}, {1'b1, 16'h4321, 8'hA7});
    @(negedge clk);
    chk(ram_we == 0, "R6 strobe only in phase 0", ram_we, 0);
    idle_bus();
    next_tick();
    chk(ram_we == 0 && cpu_wait_n == 1, "R6 idle after write", {ram_we, cpu_wait_n}, 2'b01);

    // R7 M1 alignment for each starting count
    for (int k = 0; k < 4; k++) begin
      int n;
      int expn;
      idle_bus();
      next_tick();
      while (nt % 4 != k) next_tick();
      expn = (k == 1 || k == 2) ? 3 - k : 0;
      cpu_m1_n = 0; cpu_mreq_n = 0; cpu_rd_n = 0; cpu_addr = 16'h0100;
      n = 0;
      next_tick();
      while (!cpu_wait_n && n < 8) begin
        n++;
        next_tick();
      end
      chk(n == expn, "R7 M1 wait length", n, expn);
      if (expn > 0) chk(nt % 4 == 0, "R7 release at wrap", nt % 4, 0);
      next_tick();
      chk(cpu_wait_n == 1, "R7 no retrigger while M1 held", cpu_wait_n, 1);
    end
    idle_bus();
    next_tick();
    finish_run();
  end
endmodule